// File: doc/BRIEF.md
# Banked Peripheral Bus Decoder with Two-Wire Control Port

This block sits between a 32-bit processor bus and a group of byte-wide peripherals. Each access presents a full address. The block splits out three fields from it: a 3-bit bank number, a 2-bit access-speed type and a word-aligned 5-bit register index. It then raises exactly one select line for the destination, in the same cycle as the access. The destinations are the internal register bank, the disc controller, and four latch registers reachable only at fast speed in the latch bank. The peripheral byte travels on data bits 23:16. Read data comes back through the block combinationally from whichever byte source is selected.

The block also holds one 8-bit control register at word index 0 of the internal bank. Its two low bits drive a pair of open-drain lines, clock and data, where a written one releases the line. A read of this register does not return the stored bits unchanged. It returns the levels seen on the two lines, a constant one, the middle stored bits, and a video flyback flag in the top bit.

Top module: `periph_bus_decoder`

## Requirements
- R1: The bank is address bits 18:16, the speed type is bits 20:19 (00 sync, 01 medium, 10 fast, 11 slow), and `destIndex` is address bits 6:2. Any access to bank 1 raises `destSel[1]` (disc controller), whatever the type.
- R2: In bank 5 with type 10 (fast), byte offsets 0x00, 0x18, 0x40 and 0x48 raise `destSel[2]`, `destSel[3]`, `destSel[4]` and `destSel[5]` respectively. Every other offset or type in bank 5 raises no select.
- R3: In bank 0, word index 0 is the control register and raises no select line. Every other bank 0 offset raises `destSel[0]` (internal registers).
- R4: `destSel` has at most one bit set, and it is all zero whenever `busValid` is low.
- R5: On a valid write, `destWrByte` equals write data bits 23:16 and `destWrite` is high.
- R6: A recognised byte read (`busWord`=0) returns the byte in bits 7:0 with zeros above. A recognised word read returns the byte in bits 23:16 and ones in every other bit. The byte comes from `regRdByte` for bank 0, from the control readback for the control register, and from `periphRdByte` otherwise.
- R7: A read that selects no destination and is not the control register returns all ones. This covers banks 2, 3, 4, 6 and 7, non-fast bank 5, and unlisted fast bank 5 offsets.
- R8: After reset the control register holds 0xFF, so neither line is pulled low.
- R9: A valid write to the control register stores write data bits 23:16 at the next clock edge. Stored bit 1 at 0 pulls the clock line low (`sclPullLow`=1), and stored bit 0 at 0 pulls the data line low (`sdaPullLow`=1).
- R10: A control register read returns bit 7 = `flyback`, bit 6 = 1, bits 5:2 = stored bits 5:2, bit 1 = `sclLevel`, bit 0 = `sdaLevel`.
- R11: A write presented while `busValid` is low leaves the control register and both line drives unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| busValid | input | 1 | Access present this cycle |
| busWrite | input | 1 | 1 = write, 0 = read |
| busWord | input | 1 | 1 = 32-bit read, 0 = byte read |
| busAddr | input | 32 | Processor address |
| busWrData | input | 32 | Write data, byte on bits 23:16 |
| busRdData | output | 32 | Read data, lane-formatted |
| regRdByte | input | 8 | Read byte from the internal register bank |
| periphRdByte | input | 8 | Read byte from the selected external peripheral |
| destSel | output | 6 | One-hot destination select |
| destIndex | output | 5 | Word index within the bank |
| destWrByte | output | 8 | Byte to write to the destination |
| destWrite | output | 1 | Valid write strobe |
| sclLevel | input | 1 | Sensed clock line level |
| sdaLevel | input | 1 | Sensed data line level |
| flyback | input | 1 | Vertical flyback active |
| sclPullLow | output | 1 | Drive clock line low |
| sdaPullLow | output | 1 | Drive data line low |

## Verification
The hardest case to reach is a control readback that differs from the stored value. This needs an external device holding a line low while the block releases it, together with flyback at a chosen level. The bench models the open-drain lines with a random external pull-down per access and randomises flyback, so readback bits 7, 1 and 0 move independently of the stored bits. Random addresses are biased toward banks 0, 1 and 5 and toward the four latch offsets, so that near-miss offsets and non-fast types in bank 5 also occur.

// File: rtl/pbd_pkg.sv
package pbd_pkg;
  localparam int NUM_DEST   = 6;
  localparam int DEST_REG   = 0;
  localparam int DEST_DISC  = 1;
  localparam int DEST_LATCH = 2;
  localparam int NUM_LATCH  = 4;

  typedef enum logic [1:0] {
    SPD_SYNC   = 2'b00,
    SPD_MEDIUM = 2'b01,
    SPD_FAST   = 2'b10,
    SPD_SLOW   = 2'b11
  } spd_e;

  typedef struct packed {
    logic                ctrlWr;
    logic                ctrlRd;
    logic [NUM_DEST-1:0] dest;
  } strobe_t;
endpackage

// File: rtl/pbd_decode.sv
module pbd_decode
  import pbd_pkg::*;
#(
  parameter int ADDR_W     = 32,
  parameter int BANK_LSB   = 16,
  parameter int BANK_W     = 3,
  parameter int TYPE_LSB   = 19,
  parameter int OFS_LSB    = 2,
  parameter int OFS_W      = 5,
  parameter int REG_BANK   = 0,
  parameter int DISC_BANK  = 1,
  parameter int LATCH_BANK = 5
) (
  input  logic              busValid,
  input  logic              busWrite,
  input  logic [ADDR_W-1:0] busAddr,
  output strobe_t           strobes,
  output logic [OFS_W-1:0]  destIndex
);
  localparam int LATCH_BYTE_OFS [NUM_LATCH] = '{'h00, 'h18, 'h40, 'h48};

  logic [BANK_W-1:0]    bank;
  spd_e                 speed;
  logic [OFS_W-1:0]     wordOfs;
  logic [NUM_LATCH-1:0] latchHit;

  assign bank      = busAddr[BANK_LSB +: BANK_W];
  assign speed     = spd_e'(busAddr[TYPE_LSB +: 2]);
  assign wordOfs   = busAddr[OFS_LSB +: OFS_W];
  assign destIndex = wordOfs;

  for (genvar i = 0; i < NUM_LATCH; i++) begin : g_latch
    assign latchHit[i] = (wordOfs == OFS_W'(LATCH_BYTE_OFS[i] >> OFS_LSB));
  end

  always_comb begin
    strobes = '0;
    if (busValid) begin
      if (bank == BANK_W'(REG_BANK)) begin
        if (wordOfs == '0) begin
          strobes.ctrlWr = busWrite;
          strobes.ctrlRd = !busWrite;
        end else begin
          strobes.dest[DEST_REG] = 1'b1;
        end
      end else if (bank == BANK_W'(DISC_BANK)) begin
        strobes.dest[DEST_DISC] = 1'b1;
      end else if (bank == BANK_W'(LATCH_BANK) && speed == SPD_FAST) begin
        strobes.dest[DEST_LATCH +: NUM_LATCH] = latchHit;
      end
    end
  end
endmodule

// File: rtl/pbd_datapath.sv
module pbd_datapath
  import pbd_pkg::*;
#(
  parameter int         DATA_W     = 32,
  parameter int         LANE_LSB   = 16,
  parameter logic [7:0] CTRL_RESET = 8'hFF
) (
  input  logic              clk,
  input  logic              rstN,
  input  strobe_t           strobes,
  input  logic              busWord,
  input  logic [DATA_W-1:0] busWrData,
  input  logic [7:0]        regRdByte,
  input  logic [7:0]        periphRdByte,
  input  logic              sclLevel,
  input  logic              sdaLevel,
  input  logic              flyback,
  output logic [DATA_W-1:0] busRdData,
  output logic [7:0]        destWrByte,
  output logic              sclPullLow,
  output logic              sdaPullLow
);
  localparam int BYTE_W = 8;

  logic [BYTE_W-1:0] ctrlQ;
  logic [BYTE_W-1:0] ctrlView;
  logic [BYTE_W-1:0] rdByte;
  logic              rdKnown;

  assign destWrByte = busWrData[LANE_LSB +: BYTE_W];

  always_ff @(posedge clk) begin
    if (!rstN)               ctrlQ <= CTRL_RESET;
    else if (strobes.ctrlWr) ctrlQ <= destWrByte;
  end

  assign sclPullLow = !ctrlQ[1];
  assign sdaPullLow = !ctrlQ[0];
  assign ctrlView   = {flyback, 1'b1, ctrlQ[5:2], sclLevel, sdaLevel};
  assign rdKnown    = strobes.ctrlRd || (|strobes.dest);

  always_comb begin
    if (strobes.ctrlRd)              rdByte = ctrlView;
    else if (strobes.dest[DEST_REG]) rdByte = regRdByte;
    else                             rdByte = periphRdByte;
  end

  always_comb begin
    busRdData = '1;
    if (rdKnown) begin
      if (busWord) begin
        busRdData[LANE_LSB +: BYTE_W] = rdByte;
      end else begin
        busRdData = '0;
        busRdData[BYTE_W-1:0] = rdByte;
      end
    end
  end
endmodule

// File: rtl/periph_bus_decoder.sv
module periph_bus_decoder
  import pbd_pkg::*;
(
  input  logic        clk,
  input  logic        rstN,
  input  logic        busValid,
  input  logic        busWrite,
  input  logic        busWord,
  input  logic [31:0] busAddr,
  input  logic [31:0] busWrData,
  output logic [31:0] busRdData,
  input  logic [7:0]  regRdByte,
  input  logic [7:0]  periphRdByte,
  output logic [5:0]  destSel,
  output logic [4:0]  destIndex,
  output logic [7:0]  destWrByte,
  output logic        destWrite,
  input  logic        sclLevel,
  input  logic        sdaLevel,
  input  logic        flyback,
  output logic        sclPullLow,
  output logic        sdaPullLow
);
  strobe_t strobes;

  pbd_decode u_decode (
    .busValid  (busValid),
    .busWrite  (busWrite),
    .busAddr   (busAddr),
    .strobes   (strobes),
    .destIndex (destIndex)
  );

  pbd_datapath u_datapath (
    .clk          (clk),
    .rstN         (rstN),
    .strobes      (strobes),
    .busWord      (busWord),
    .busWrData    (busWrData),
    .regRdByte    (regRdByte),
    .periphRdByte (periphRdByte),
    .sclLevel     (sclLevel),
    .sdaLevel     (sdaLevel),
    .flyback      (flyback),
    .busRdData    (busRdData),
    .destWrByte   (destWrByte),
    .sclPullLow   (sclPullLow),
    .sdaPullLow   (sdaPullLow)
  );

  assign destSel   = strobes.dest;
  assign destWrite = busValid && busWrite;
endmodule

// File: rtl/periph_bus_decoder_chk.sv
module periph_bus_decoder_chk (
  input logic        clk,
  input logic        rstN,
  input logic        busValid,
  input logic        busWrite,
  input logic        busWord,
  input logic [31:0] busAddr,
  input logic [31:0] busRdData,
  input logic [5:0]  destSel,
  input logic        sclPullLow,
  input logic        sdaPullLow
);
  logic [2:0] bankF;
  assign bankF = busAddr[18:16];

  AST_SEL_ONEHOT: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0(destSel)); // R4

  AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (!rstN)
    !busValid |-> destSel == 6'd0); // R4

  AST_DISC_SEL: assert property (@(posedge clk) disable iff (!rstN)
    (busValid && bankF == 3'd1) |-> destSel[1]); // R1

  AST_WORD_FILL: assert property (@(posedge clk) disable iff (!rstN)
    (busValid && !busWrite && busWord) |->
      (busRdData[31:24] == 8'hFF && busRdData[15:0] == 16'hFFFF)); // R6

  AST_UNMAPPED_ONES: assert property (@(posedge clk) disable iff (!rstN)
    (busValid && !busWrite && bankF != 3'd0 && bankF != 3'd1 && bankF != 3'd5)
      |-> busRdData == 32'hFFFF_FFFF); // R7

  AST_LINES_HOLD: assert property (@(posedge clk) disable iff (!rstN)
    !(busValid && busWrite) |=> ($stable(sclPullLow) && $stable(sdaPullLow))); // R11
endmodule

bind periph_bus_decoder periph_bus_decoder_chk u_chk (
  .clk        (clk),
  .rstN       (rstN),
  .busValid   (busValid),
  .busWrite   (busWrite),
  .busWord    (busWord),
  .busAddr    (busAddr),
  .busRdData  (busRdData),
  .destSel    (destSel),
  .sclPullLow (sclPullLow),
  .sdaPullLow (sdaPullLow)
);

// File: tb/periph_bus_decoder_tb.sv
`timescale 1ns/1ps
module periph_bus_decoder_tb;
  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        busValid = 1'b0, busWrite = 1'b0, busWord = 1'b0;
  logic [31:0] busAddr = '0, busWrData = '0;
  logic [31:0] busRdData;
  logic [7:0]  regRdByte = '0, periphRdByte = '0;
  logic [5:0]  destSel;
  logic [4:0]  destIndex;
  logic [7:0]  destWrByte;
  logic        destWrite;
  logic        flyback = 1'b0, extSclLow = 1'b0, extSdaLow = 1'b0;
  logic        sclPullLow, sdaPullLow;
  wire         sclLevel = !(sclPullLow || extSclLow);
  wire         sdaLevel = !(sdaPullLow || extSdaLow);

  int checks = 0, errors = 0;
  bit done = 0;
  logic [7:0] ctrlModel = 8'hFF;

  always #2 clk = !clk;

  periph_bus_decoder u_dut (
    .clk(clk), .rstN(rstN), .busValid(busValid), .busWrite(busWrite), .busWord(busWord),
    .busAddr(busAddr), .busWrData(busWrData), .busRdData(busRdData),
    .regRdByte(regRdByte), .periphRdByte(periphRdByte), .destSel(destSel),
    .destIndex(destIndex), .destWrByte(destWrByte), .destWrite(destWrite),
    .sclLevel(sclLevel), .sdaLevel(sdaLevel), .flyback(flyback),
    .sclPullLow(sclPullLow), .sdaPullLow(sdaPullLow)
  );

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  function automatic logic [31:0] mkAddr(input logic [2:0] bank, input logic [1:0] ty,
                                         input logic [6:0] ofs, input logic [31:0] junk);
    logic [31:0] a;
    a = junk;
    a[20:19] = ty;
    a[18:16] = bank;
    a[6:0]   = ofs;
    return a;
  endfunction

  function automatic logic [5:0] expSel(input logic [31:0] a);
    logic [6:0] ofs;
    ofs = a[6:0] & 7'h7C;
    case (a[18:16])
      3'd0: return (ofs != 7'h00) ? 6'b000001 : 6'b000000;
      3'd1: return 6'b000010;
      3'd5: if (a[20:19] == 2'b10) begin
        case (ofs)
          7'h00: return 6'b000100;
          7'h18: return 6'b001000;
          7'h40: return 6'b010000;
          7'h48: return 6'b100000;
          default: return 6'b000000;
        endcase
      end
      default: return 6'b000000;
    endcase
    return 6'b000000;
  endfunction

  function automatic string tagOf(input logic [31:0] a);
    case (a[18:16])
      3'd0: return "R3";
      3'd1: return "R1";
      3'd5: return "R2";
      default: return "R7";
    endcase
  endfunction

  task automatic access(input logic wr, input logic word, input logic [31:0] a,
                        input logic [31:0] d);
    logic isCtrl;
    logic [5:0] es;
    logic [7:0] b;
    logic [31:0] er;
    @(negedge clk);
    busValid = 1'b1; busWrite = wr; busWord = word; busAddr = a; busWrData = d;
    regRdByte = 8'($urandom); periphRdByte = 8'($urandom);
    flyback = 1'($urandom); extSclLow = 1'($urandom); extSdaLow = 1'($urandom);
    #1;
    isCtrl = (a[18:16] == 3'd0) && ((a[6:0] & 7'h7C) == 7'h00);
    es = expSel(a);
    check({tagOf(a), " sel"}, 32'(destSel), 32'(es));
    check("R1 index", 32'(destIndex), 32'(a[6:2]));
    if (wr) begin
      check("R5 wrbyte", 32'(destWrByte), 32'(d[23:16]));
      check("R5 wrstrobe", 32'(destWrite), 32'd1);
    end else begin
      if (isCtrl)      b = {flyback, 1'b1, ctrlModel[5:2], sclLevel, sdaLevel};
      else if (es[0])  b = regRdByte;
      else             b = periphRdByte;
      if (!isCtrl && es == 6'd0) er = 32'hFFFF_FFFF;
      else if (word)             er = {8'hFF, b, 16'hFFFF};
      else                       er = {24'h0, b};
      check(isCtrl ? "R10 ctrl read" : (es == 0 ? "R7 unmapped" : "R6 read"), busRdData, er);
    end
    @(posedge clk);
    #1;
    if (wr && isCtrl) ctrlModel = d[23:16];
    busValid = 1'b0;
    check("R9 pulls", {30'd0, sclPullLow, sdaPullLow}, {30'd0, !ctrlModel[1], !ctrlModel[0]});
  endtask

  initial begin
    #400000;
    if (!done) begin
      errors++;
      $display("FAIL watchdog actual=hung expected=finish");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd20240611));
    repeat (3) @(posedge clk);
    #1 rstN = 1'b1;
    #1;
    check("R8 reset pulls", {30'd0, sclPullLow, sdaPullLow}, 32'd0);
    check("R4 idle sel", 32'(destSel), 32'd0);
    // R8/R10: reset value visible through readback
    access(1'b0, 1'b0, mkAddr(3'd0, 2'b00, 7'h00, 32'h0), 32'h0);
    // R9: pull both lines low, then release clock only
    access(1'b1, 1'b0, mkAddr(3'd0, 2'b01, 7'h00, 32'h0), 32'h00A8_0000);
    access(1'b0, 1'b1, mkAddr(3'd0, 2'b00, 7'h01, 32'h0), 32'h0);
    access(1'b1, 1'b0, mkAddr(3'd0, 2'b00, 7'h02, 32'h0), 32'h0056_0000);
    access(1'b0, 1'b0, mkAddr(3'd0, 2'b11, 7'h00, 32'h0), 32'h0);
    // R11: write with valid low leaves control untouched
    @(negedge clk);
    busValid = 1'b0; busWrite = 1'b1; busAddr = mkAddr(3'd0, 2'b00, 7'h00, 32'h0);
    busWrData = 32'h00FF_0000;
    #1 check("R4 invalid sel", 32'(destSel), 32'd0);
    @(posedge clk); #1 busWrite = 1'b0;
    check("R11 pulls held", {30'd0, sclPullLow, sdaPullLow}, {30'd0, !ctrlModel[1], !ctrlModel[0]});
    // R2: latch offsets, near misses, wrong type
    access(1'b0, 1'b1, mkAddr(3'd5, 2'b10, 7'h48, 32'h0), 32'h0);
    access(1'b0, 1'b0, mkAddr(3'd5, 2'b10, 7'h44, 32'h0), 32'h0);
    access(1'b0, 1'b1, mkAddr(3'd5, 2'b11, 7'h18, 32'h0), 32'h0);
    access(1'b1, 1'b0, mkAddr(3'd5, 2'b10, 7'h40, 32'h0), 32'h0012_3456);
    access(1'b0, 1'b1, mkAddr(3'd7, 2'b10, 7'h00, 32'h0), 32'h0);
    // Random mix
    for (int n = 0; n < 400; n++) begin
      logic [2:0] bk;
      logic [6:0] of;
      int pick;
      pick = $urandom_range(0, 9);
      bk = (pick < 3) ? 3'd0 : (pick < 5) ? 3'd1 : (pick < 8) ? 3'd5 : 3'($urandom);
      case ($urandom_range(0, 5))
        0: of = 7'h00;
        1: of = 7'h18;
        2: of = 7'h40;
        3: of = 7'h48;
        default: of = 7'($urandom);
      endcase
      access(1'($urandom), 1'($urandom),
             mkAddr(bk, 2'($urandom), of, $urandom), $urandom);
    end
    done = 1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule